// File: doc/BRIEF.md
# Overlapping 110 Sequence Detector

This block watches a serial bit stream, one bit per clock cycle, and flags every cycle in which the three most recent bits, oldest first, are 1, 1, 0. The check slides along the stream one bit at a time. Every three-bit window is examined, so a match can share bits with the stream before it. The fixed blocks of three that would start at bit 1, bit 4, bit 7 and so on are never used.

The match flag is a Moore output. It is decoded from the registered state alone, so the serial input has no combinational path to the output. The default build tracks progress through the pattern with four states: idle, one 1 seen, two or more 1s seen, and pattern complete. Two parameters select variants that behave the same at the ports. One keeps a three-bit history register instead of the progress states. The other stores the progress states one-hot.

Top module: `seq110_detector`

## Requirements
- R1: `rst` is synchronous and active high. After any rising edge at which `rst` is 1, `match_out` reads 0 and all earlier input progress is lost.
- R2: `match_out` is 1 in the cycle after the rising edge that samples a 0, when the two samples before it since the last reset were 1 and 1 (arrival order 1, 1, 0). In every other cycle it is 0.
- R3: Windows overlap. A run of any number (two or more) of 1s followed by a 0 gives exactly one match. The stream 1,1,0,1,1,0 gives two matches, three cycles apart.
- R4: `match_out` is never 1 in two consecutive cycles.
- R5: A change of `serial_in` between rising edges leaves `match_out` unchanged until the next rising edge.
- R6: Bits presented while `rst` is 1 are ignored. A 1,1 held under reset followed by a 0 after release gives no match.
- R7: For every input sequence, the variants give the same `match_out` as the default build: `HISTORY_IMPL=1` (three-bit history, newest bit shifted into bit 0, match when it equals 3'b110) and `ONE_HOT=1` (progress states stored one-hot).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| serial_in | input | 1 | Serial data bit, sampled each rising edge |
| match_out | output | 1 | High for one cycle after the bits 1,1,0 have been received |

## Verification
The stimulus includes the following streams:

| Stream | What it tells apart |
|---|---|
| Plain 1,1,0 | Correct arrival order from the reverse order |
| Long runs of 1s ending in 0 | Staying in the "two 1s" state from falling back to an earlier state |
| 1,1,0,1,1,0 and 1,1,0,1,0 | True overlap from a false re-trigger after a match |
| 1,0,1,0 and 0,1,1,1 | Near misses that must stay quiet |
| Reset asserted part-way through the pattern | A reset that really clears progress from one that leaves some behind |
| A long pseudo-random stream fed to all three variants | Compared against a history model to show the variants behave the same |

// File: rtl/seq110_pkg.sv
package seq110_pkg;

   localparam int          PAT_LEN  = 3;
   localparam logic [2:0]  PAT_BITS = 3'b110;
   localparam int          NUM_PROG = 4;

   typedef enum logic [1:0] {
      PR_NONE = 2'd0,
      PR_ONE  = 2'd1,
      PR_TWO  = 2'd2,
      PR_HIT  = 2'd3
   } prog_e;

   function automatic prog_e prog_next(prog_e cur, logic b);
      prog_e nxt;
      case (cur)
         PR_NONE: nxt = b ? PR_ONE : PR_NONE;
         PR_ONE:  nxt = b ? PR_TWO : PR_NONE;
         PR_TWO:  nxt = b ? PR_TWO : PR_HIT;
         default: nxt = b ? PR_ONE : PR_NONE;
      endcase
      return nxt;
   endfunction

   function automatic logic [NUM_PROG-1:0] prog_onehot(prog_e s);
      logic [NUM_PROG-1:0] v;
      v = '0;
      v[s] = 1'b1;
      return v;
   endfunction

endpackage

// File: rtl/seq110_progress_fsm.sv
module seq110_progress_fsm #(
   parameter int ONE_HOT = 0
) (
   input  logic clk,
   input  logic rst,
   input  logic bit_in,
   output logic hit
);
   import seq110_pkg::*;

   generate
      if (ONE_HOT != 0) begin : g_onehot
         logic [NUM_PROG-1:0] oh_q;
         prog_e               cur;

         always_comb begin
            cur = PR_NONE;
            for (int k = 0; k < NUM_PROG; k++) begin
               if (oh_q[k]) cur = prog_e'(k[1:0]);
            end
         end

         always_ff @(posedge clk) begin
            if (rst) oh_q <= prog_onehot(PR_NONE);
            else     oh_q <= prog_onehot(prog_next(cur, bit_in));
         end

         assign hit = oh_q[PR_HIT];

         // R7: one-hot storage must always hold exactly one active state
         p_onehot_legal_r7: assert property (@(posedge clk) disable iff (rst)
            $countones(oh_q) == 1);
         // R3: a further 1 while two 1s are pending keeps that progress
         p_keep_two_r3: assert property (@(posedge clk) disable iff (rst)
            (oh_q[PR_TWO] && bit_in) |=> oh_q[PR_TWO]);
      end else begin : g_binary
         prog_e st_q;

         always_ff @(posedge clk) begin
            if (rst) st_q <= PR_NONE;
            else     st_q <= prog_next(st_q, bit_in);
         end

         assign hit = (st_q == PR_HIT);

         // R3: a further 1 while two 1s are pending keeps that progress
         p_keep_two_r3: assert property (@(posedge clk) disable iff (rst)
            (st_q == PR_TWO && bit_in) |=> (st_q == PR_TWO));
         // R2: a 0 after two 1s completes the pattern
         p_two_then_zero_r2: assert property (@(posedge clk) disable iff (rst)
            (st_q == PR_TWO && !bit_in) |=> (st_q == PR_HIT));
      end
   endgenerate

endmodule

// File: rtl/seq110_history_fsm.sv
module seq110_history_fsm (
   input  logic clk,
   input  logic rst,
   input  logic bit_in,
   output logic hit
);
   import seq110_pkg::*;

   logic [PAT_LEN-1:0] hist_q;

   always_ff @(posedge clk) begin
      if (rst) hist_q <= '0;
      else     hist_q <= {hist_q[PAT_LEN-2:0], bit_in};
   end

   assign hit = (hist_q == PAT_BITS);

   // R7: newest sample lands in bit 0, older samples move up
   p_shift_in_r7: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> (hist_q[0] == $past(bit_in)) && (hist_q[1] == $past(hist_q[0])));

endmodule

// File: rtl/seq110_detector.sv
module seq110_detector #(
   parameter int HISTORY_IMPL = 0,
   parameter int ONE_HOT      = 0
) (
   input  logic clk,
   input  logic rst,
   input  logic serial_in,
   output logic match_out
);

   initial begin
      assert (HISTORY_IMPL == 0 || HISTORY_IMPL == 1)
         else $error("HISTORY_IMPL must be 0 or 1");
      assert (ONE_HOT == 0 || ONE_HOT == 1)
         else $error("ONE_HOT must be 0 or 1");
   end

   generate
      if (HISTORY_IMPL != 0) begin : g_hist
         seq110_history_fsm u_core (
            .clk    (clk),
            .rst    (rst),
            .bit_in (serial_in),
            .hit    (match_out)
         );
      end else begin : g_prog
         seq110_progress_fsm #(.ONE_HOT(ONE_HOT)) u_core (
            .clk    (clk),
            .rst    (rst),
            .bit_in (serial_in),
            .hit    (match_out)
         );
      end
   endgenerate

   // R1: the cycle after a reset edge never shows a match
   p_reset_clears_r1: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> !match_out);
   // R4: a match lasts a single cycle
   p_single_pulse_r4: assert property (@(posedge clk) disable iff (rst)
      match_out |=> !match_out);
   // R2: a match implies the last three samples were 1,1,0
   p_window_r2: assert property (@(posedge clk) disable iff (rst)
      match_out |-> (!$past(serial_in, 1) && $past(serial_in, 2) && $past(serial_in, 3)));

endmodule

// File: tb/seq110_detector_bench.sv
module seq110_detector_bench;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic serial_in = 1'b0;
   logic m_def, m_hist, m_oh;

   int n_cmp = 0;
   int n_bad = 0;
   logic [2:0] model_h = 3'b000;

   always #10 clk = ~clk;

   seq110_detector u_seq110_detector (
      .clk(clk), .rst(rst), .serial_in(serial_in), .match_out(m_def));
   seq110_detector #(.HISTORY_IMPL(1)) u_alt_hist (
      .clk(clk), .rst(rst), .serial_in(serial_in), .match_out(m_hist));
   seq110_detector #(.ONE_HOT(1)) u_alt_oh (
      .clk(clk), .rst(rst), .serial_in(serial_in), .match_out(m_oh));

   task automatic cmp(input string req, input logic act, input logic exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
      end
   endtask

   // one cycle: drive at falling edge, sample 5 ns after rising edge
   task automatic step(input logic b, input logic r, input string req);
      logic exp;
      @(negedge clk);
      serial_in = b;
      rst = r;
      @(posedge clk);
      if (r) model_h = 3'b000;
      else   model_h = {model_h[1:0], b};
      exp = !r && (model_h == 3'b110);
      #5;
      cmp(req, m_def, exp);
      cmp({req, " R7 hist"}, m_hist, m_def);
      cmp({req, " R7 onehot"}, m_oh, m_def);
   endtask

   task automatic t_reset;
      step(1'b1, 1'b1, "R1 reset");
      step(1'b0, 1'b1, "R1 reset");
      cmp("R1 reset out", m_def, 1'b0);
   endtask

   task automatic t_basic;
      step(1'b1, 1'b0, "R2 basic");
      step(1'b1, 1'b0, "R2 basic");
      step(1'b0, 1'b0, "R2 basic");
      cmp("R2 hit", m_def, 1'b1);
      step(1'b0, 1'b0, "R4 after hit");
      cmp("R4 drop", m_def, 1'b0);
      // reverse order 0,1,1 must stay quiet
      step(1'b0, 1'b0, "R2 reverse");
      step(1'b1, 1'b0, "R2 reverse");
      step(1'b1, 1'b0, "R2 reverse");
      cmp("R2 no hit on 011", m_def, 1'b0);
   endtask

   task automatic t_runs;
      for (int len = 2; len <= 6; len++) begin
         int hits = 0;
         step(1'b0, 1'b1, "R1 clear");
         for (int k = 0; k < len; k++) begin
            step(1'b1, 1'b0, "R3 run");
            if (m_def) hits++;
         end
         step(1'b0, 1'b0, "R3 run end");
         if (m_def) hits++;
         step(1'b0, 1'b0, "R3 run tail");
         if (m_def) hits++;
         n_cmp++;
         if (hits != 1) begin
            n_bad++;
            $display("FAIL R3 run of %0d ones: actual %0d hits expected 1", len, hits);
         end
      end
   endtask

   task automatic t_overlap;
      step(1'b0, 1'b1, "R1 clear");
      step(1'b1, 1'b0, "R3 overlap");
      step(1'b1, 1'b0, "R3 overlap");
      step(1'b0, 1'b0, "R3 overlap");
      cmp("R3 first hit", m_def, 1'b1);
      step(1'b1, 1'b0, "R3 overlap");
      step(1'b1, 1'b0, "R3 overlap");
      step(1'b0, 1'b0, "R3 overlap");
      cmp("R3 second hit", m_def, 1'b1);
      step(1'b1, 1'b0, "R3 no retrigger");
      step(1'b0, 1'b0, "R3 no retrigger");
      cmp("R3 1101,0 quiet", m_def, 1'b0);
      step(1'b1, 1'b0, "R2 1010");
      step(1'b0, 1'b0, "R2 1010");
      cmp("R2 1010 quiet", m_def, 1'b0);
   endtask

   task automatic t_between_edges;
      step(1'b1, 1'b1, "R1 clear");
      step(1'b1, 1'b0, "R5 setup");
      step(1'b1, 1'b0, "R5 setup");
      step(1'b0, 1'b0, "R5 setup");
      serial_in = 1'b1;
      #3;
      cmp("R5 hold high", m_def, 1'b1);
      step(1'b1, 1'b0, "R5 next");
      serial_in = 1'b0;
      #3;
      cmp("R5 hold low", m_def, 1'b0);
   endtask

   task automatic t_reset_ignore;
      step(1'b0, 1'b1, "R6 clear");
      step(1'b1, 1'b1, "R6 under reset");
      step(1'b1, 1'b1, "R6 under reset");
      step(1'b0, 1'b0, "R6 after release");
      cmp("R6 no hit", m_def, 1'b0);
      step(1'b1, 1'b0, "R1 mid");
      step(1'b1, 1'b0, "R1 mid");
      step(1'b0, 1'b1, "R1 mid reset");
      cmp("R1 mid reset quiet", m_def, 1'b0);
      step(1'b0, 1'b0, "R1 progress lost");
      cmp("R1 progress lost", m_def, 1'b0);
   endtask

   task automatic t_random;
      logic [15:0] lfsr = 16'hACE1;
      step(1'b0, 1'b1, "R1 clear");
      for (int k = 0; k < 400; k++) begin
         step(lfsr[0], 1'b0, "R2 random");
         lfsr = {lfsr[0] ^ lfsr[2] ^ lfsr[3] ^ lfsr[5], lfsr[15:1]};
      end
   endtask

   initial begin
      #2_000_000;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      t_reset;
      t_basic;
      t_runs;
      t_overlap;
      t_between_edges;
      t_reset_ignore;
      t_random;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule